// File: doc/BRIEF.md
# Outbound Descriptor-Chain Stream Reader

This engine feeds a byte-consuming client from a chain of data descriptors held in memory. A start pulse gives it the address of the first data descriptor and the address of a context descriptor. The engine fetches the data descriptor, then reads that descriptor's buffer one memory word at a time. It delivers the bytes in address order on a valid/ready byte interface. The bytes are grouped into chunks, and no chunk is longer than a set cap (2048 bytes by default).

When the buffer pointer reaches the descriptor's end address, the engine completes the descriptor in a fixed order:
1. It pulses the data interrupt if the descriptor asks for one.
2. It writes the descriptor back to memory.
3. At end of list, it sets the disable bit in the context flags word by read-modify-write, raises its end-of-list flag and stops.
4. Otherwise, it follows the next pointer, fetches that descriptor and reloads the buffer pointer from the new start address.

The saved descriptor pointer and saved buffer pointer are visible as outputs at all times.

Top module: `dcr_chain_reader`

## Requirements
- R1: After reset `running_o`, `eol_o`, `out_valid_o`, `mem_req_o`, `data_irq_o` are 0 and both saved pointers are 0.
- R2: A `start_i` pulse while stopped loads the saved descriptor pointer from `desc_addr_i`, clears `eol_o`, sets `running_o` and reads the four descriptor words at offsets 0 (next pointer), 4 (buffer start), 8 (flags), 12 (buffer end, exclusive).
- R3: Bytes from buffer start up to but not including buffer end are sent in ascending address order. The byte at address a is bits [8*(a mod 4)+7 : 8*(a mod 4)] of the word at a with its two low bits cleared.
- R4: Each chunk holds min(end − pointer, MAX_CHUNK) bytes, and `out_last_o` is high on exactly the final byte of every chunk.
- R5: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o` and `out_last_o` stay unchanged into the next cycle.
- R6: `saved_buf_ptr_o` rises by one for each accepted byte and equals the buffer end once the descriptor completes.
- R7: A descriptor whose buffer end is not above its start completes with no bytes sent.
- R8: On completion of a descriptor whose flags bit 4 is set, `data_irq_o` pulses high for exactly one cycle. With bit 4 clear there is no pulse.
- R9: On completion, the four descriptor words are written back to their own addresses with their fetched values.
- R10: If flags bit 0 is clear, the next pointer becomes the saved descriptor pointer, that descriptor is fetched and streaming resumes from its buffer start.
- R11: If flags bit 0 is set, the context word at context address + 4 is read and rewritten with bit 15 set and all other bits kept. Then `eol_o` goes to 1, `running_o` goes to 0, and no further byte is offered.
- R12: `start_i` has no effect while the engine is running.
- R13: A memory request that is not yet acknowledged keeps `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only while stopped |
| desc_addr_i | input | WORD_W | Address of the first data descriptor |
| ctx_addr_i | input | WORD_W | Address of the context descriptor |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | WORD_W | Word-aligned byte address |
| mem_wdata_o | output | WORD_W | Write data |
| mem_ack_i | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata_i | input | WORD_W | Read data |
| out_valid_o | output | 1 | Byte available |
| out_ready_i | input | 1 | Client accepts byte |
| out_data_o | output | 8 | Byte value |
| out_last_o | output | 1 | Final byte of the current chunk |
| data_irq_o | output | 1 | One-cycle data interrupt event |
| running_o | output | 1 | Channel is running |
| eol_o | output | 1 | End of list reached |
| saved_desc_ptr_o | output | WORD_W | Address of the current data descriptor |
| saved_buf_ptr_o | output | WORD_W | Address of the next buffer byte |

## Verification
The bench covers several boundary cases:
- **Buffer starting mid-word.** A buffer starts on an odd address, so a wrong byte-lane pick or a stale cached word shows up as corrupted bytes.
- **Zero-length descriptor in a chain.** This descriptor carries the interrupt flag. A design that skips completion for empty buffers would lose the interrupt and the write-back. A design that sends a byte anyway would lengthen the stream.
- **Buffer just over the chunk cap, under stalls.** A buffer of 2050 bytes is read while the client stalls. A wrong cap or counter moves the chunk marker off positions 2047 and 2049. A design that ignores the stall drops or repeats bytes.
- **Context write-back and late start.** The context word's other bits must survive the write-back, and the write count must match four words per descriptor plus one context word. A start pulse in the middle of a run must leave the saved descriptor pointer untouched.

// File: rtl/dcr_pkg.sv
// Shared constants and the controller state type for the chain reader.
package dcr_pkg;
    localparam int DESC_WORDS  = 4;   // words per data descriptor
    localparam int W_NEXT      = 0;   // word index: next descriptor pointer
    localparam int W_START     = 1;   // word index: buffer start
    localparam int W_FLAGS     = 2;   // word index: flags / metadata
    localparam int W_END       = 3;   // word index: buffer end (exclusive)
    localparam int FLG_EOL     = 0;   // flags bit: last descriptor in chain
    localparam int FLG_INTR    = 4;   // flags bit: interrupt on completion
    localparam int CTX_DIS_BIT = 15;  // context flags bit: disabled
    localparam int CTX_FLG_OFS = 4;   // byte offset of context flags word

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_CHUNK,
        S_SEND,
        S_DONE,
        S_WBACK,
        S_CTX_RD,
        S_CTX_WR,
        S_NEXT
    } dcr_state_e;
endpackage

// File: rtl/dcr_desc_store.sv
// Holds the four words of the current data descriptor.
// Assumes words are loaded one per cycle by index; read port is by index too.
module dcr_desc_store import dcr_pkg::*; #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [WORD_W-1:0] ld_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] next_ptr,
    output logic [WORD_W-1:0] buf_start,
    output logic [WORD_W-1:0] buf_end,
    output logic              flag_eol,
    output logic              flag_intr
);
    logic [WORD_W-1:0] words_q [DESC_WORDS];

    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        // Capture word g when it is the one being loaded.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words_q[g] <= '0;
            else if (ld_en && (ld_idx == IDX_W'(g)))
                words_q[g] <= ld_word;
        end
    end

    assign rd_word   = words_q[rd_idx];
    assign next_ptr  = words_q[W_NEXT];
    assign buf_start = words_q[W_START];
    assign buf_end   = words_q[W_END];
    assign flag_eol  = words_q[W_FLAGS][FLG_EOL];
    assign flag_intr = words_q[W_FLAGS][FLG_INTR];
endmodule

// File: rtl/dcr_chunk_sizer.sv
// Computes the bytes left in the buffer and the capped size of the next chunk.
// Assumes an end address at or below the pointer means nothing is left.
module dcr_chunk_sizer #(
    parameter int WORD_W    = 32,
    parameter int MAX_CHUNK = 2048,
    parameter int LEN_W     = 12
) (
    input  logic [WORD_W-1:0] cur_ptr,
    input  logic [WORD_W-1:0] end_ptr,
    output logic              empty,
    output logic [LEN_W-1:0]  chunk_len
);
    logic [WORD_W-1:0] remain;

    // Remaining bytes and cap selection.
    always_comb begin
        remain    = (end_ptr > cur_ptr) ? (end_ptr - cur_ptr) : '0;
        empty     = (remain == '0);
        chunk_len = (remain > WORD_W'(MAX_CHUNK)) ? LEN_W'(MAX_CHUNK)
                                                  : remain[LEN_W-1:0];
    end
endmodule

// File: rtl/dcr_word_cache.sv
// One-entry word cache for buffer reads, with byte lane selection.
// Assumes buffer memory does not change while a chain is being read.
module dcr_word_cache #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill,
    input  logic [WORD_W-1:0] fill_addr,
    input  logic [WORD_W-1:0] fill_data,
    input  logic [WORD_W-1:0] look_addr,
    output logic              hit,
    output logic [7:0]        byte_o
);
    localparam int LANES = WORD_W / 8;
    localparam int LB    = $clog2(LANES);

    logic                 valid_q;
    logic [WORD_W-LB-1:0] tag_q;
    logic [WORD_W-1:0]    data_q;

    // Tag, data and valid bit of the cached word.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            data_q  <= '0;
        end else if (fill) begin
            valid_q <= 1'b1;
            tag_q   <= fill_addr[WORD_W-1:LB];
            data_q  <= fill_data;
        end
    end

    assign hit    = valid_q && (tag_q == look_addr[WORD_W-1:LB]);
    assign byte_o = data_q[8*look_addr[LB-1:0] +: 8];
endmodule

// File: rtl/dcr_chain_reader.sv
// Walks a linked list of data descriptors and streams each buffer out as
// capped chunks of bytes. On completion of a descriptor it pulses the
// interrupt if requested, writes the descriptor back, then either follows
// the next pointer or marks the context disabled and stops.
// Assumes a single-outstanding memory port with a one-cycle acknowledge.
module dcr_chain_reader import dcr_pkg::*; #(
    parameter int WORD_W    = 32,
    parameter int MAX_CHUNK = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] desc_addr_i,
    input  logic [WORD_W-1:0] ctx_addr_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [7:0]        out_data_o,
    output logic              out_last_o,
    output logic              data_irq_o,
    output logic              running_o,
    output logic              eol_o,
    output logic [WORD_W-1:0] saved_desc_ptr_o,
    output logic [WORD_W-1:0] saved_buf_ptr_o
);
    localparam int LEN_W = $clog2(MAX_CHUNK + 1);
    localparam int IDX_W = $clog2(DESC_WORDS);
    localparam int LB    = $clog2(WORD_W / 8);

    dcr_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] desc_ptr_q, ctx_ptr_q, buf_ptr_q, ctx_word_q;
    logic [LEN_W-1:0]  len_q, cnt_q;
    logic              running_q, eol_q, irq_q;

    logic [WORD_W-1:0] rd_word, next_ptr, buf_start, buf_end;
    logic              flag_eol, flag_intr;
    logic              empty, hit;
    logic [LEN_W-1:0]  chunk_len;
    logic [7:0]        cache_byte;
    logic [WORD_W-1:0] word_ofs, buf_word_addr, ctx_flg_addr;
    logic              beat, chunk_end;

    dcr_desc_store #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (state_q == S_FETCH && mem_ack_i),
        .ld_idx    (idx_q),
        .ld_word   (mem_rdata_i),
        .rd_idx    (idx_q),
        .rd_word   (rd_word),
        .next_ptr  (next_ptr),
        .buf_start (buf_start),
        .buf_end   (buf_end),
        .flag_eol  (flag_eol),
        .flag_intr (flag_intr)
    );

    dcr_chunk_sizer #(.WORD_W(WORD_W), .MAX_CHUNK(MAX_CHUNK), .LEN_W(LEN_W)) u_sizer (
        .cur_ptr   (buf_ptr_q),
        .end_ptr   (buf_end),
        .empty     (empty),
        .chunk_len (chunk_len)
    );

    dcr_word_cache #(.WORD_W(WORD_W)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (state_q == S_IDLE && start_i),
        .fill      (state_q == S_SEND && !hit && mem_ack_i),
        .fill_addr (buf_word_addr),
        .fill_data (mem_rdata_i),
        .look_addr (buf_ptr_q),
        .hit       (hit),
        .byte_o    (cache_byte)
    );

    // Address helpers for descriptor words, buffer words and context flags.
    always_comb begin
        word_ofs      = WORD_W'(idx_q) << LB;
        buf_word_addr = {buf_ptr_q[WORD_W-1:LB], {LB{1'b0}}};
        ctx_flg_addr  = ctx_ptr_q + WORD_W'(CTX_FLG_OFS);
    end

    // Memory request decode from the controller state.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_ptr_q + word_ofs;
            end
            S_SEND: begin
                mem_req_o  = !hit;
                mem_addr_o = hit ? '0 : buf_word_addr;
            end
            S_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_ptr_q + word_ofs;
                mem_wdata_o = rd_word;
            end
            S_CTX_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ctx_flg_addr;
            end
            S_CTX_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ctx_flg_addr;
                mem_wdata_o = ctx_word_q | (WORD_W'(1) << CTX_DIS_BIT);
            end
            default: ;
        endcase
    end

    // Byte interface decode.
    always_comb begin
        out_valid_o = (state_q == S_SEND) && hit;
        out_data_o  = out_valid_o ? cache_byte : 8'h00;
        chunk_end   = (cnt_q == len_q - LEN_W'(1));
        out_last_o  = out_valid_o && chunk_end;
        beat        = out_valid_o && out_ready_i;
    end

    // Controller sequencing: fetch, stream, complete, chain or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            idx_q      <= '0;
            desc_ptr_q <= '0;
            ctx_ptr_q  <= '0;
            buf_ptr_q  <= '0;
            ctx_word_q <= '0;
            len_q      <= '0;
            cnt_q      <= '0;
            running_q  <= 1'b0;
            eol_q      <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        desc_ptr_q <= desc_addr_i;
                        ctx_ptr_q  <= ctx_addr_i;
                        running_q  <= 1'b1;
                        eol_q      <= 1'b0;
                        idx_q      <= '0;
                        state_q    <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (mem_ack_i) begin
                        idx_q <= idx_q + IDX_W'(1);
                        if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
                            buf_ptr_q <= buf_start;
                            state_q   <= S_CHUNK;
                        end
                    end
                end
                S_CHUNK: begin
                    cnt_q <= '0;
                    len_q <= chunk_len;
                    state_q <= empty ? S_DONE : S_SEND;
                end
                S_SEND: begin
                    if (beat) begin
                        buf_ptr_q <= buf_ptr_q + WORD_W'(1);
                        cnt_q     <= cnt_q + LEN_W'(1);
                        if (chunk_end)
                            state_q <= S_CHUNK;
                    end
                end
                S_DONE: begin
                    irq_q   <= flag_intr;
                    idx_q   <= '0;
                    state_q <= S_WBACK;
                end
                S_WBACK: begin
                    if (mem_ack_i) begin
                        idx_q <= idx_q + IDX_W'(1);
                        if (idx_q == IDX_W'(DESC_WORDS - 1))
                            state_q <= flag_eol ? S_CTX_RD : S_NEXT;
                    end
                end
                S_CTX_RD: begin
                    if (mem_ack_i) begin
                        ctx_word_q <= mem_rdata_i;
                        state_q    <= S_CTX_WR;
                    end
                end
                S_CTX_WR: begin
                    if (mem_ack_i) begin
                        running_q <= 1'b0;
                        eol_q     <= 1'b1;
                        state_q   <= S_IDLE;
                    end
                end
                S_NEXT: begin
                    desc_ptr_q <= next_ptr;
                    idx_q      <= '0;
                    state_q    <= S_FETCH;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign data_irq_o       = irq_q;
    assign running_o        = running_q;
    assign eol_o            = eol_q;
    assign saved_desc_ptr_o = desc_ptr_q;
    assign saved_buf_ptr_o  = buf_ptr_q;
endmodule

// File: rtl/dcr_chain_reader_chk.sv
// Protocol and ordering checks for the chain reader, watching its ports only.
module dcr_chain_reader_chk #(
    parameter int WORD_W    = 32,
    parameter int MAX_CHUNK = 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid_o,
    input logic              out_ready_i,
    input logic [7:0]        out_data_o,
    input logic              out_last_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [WORD_W-1:0] mem_addr_o,
    input logic [WORD_W-1:0] mem_wdata_o,
    input logic              mem_ack_i,
    input logic              running_o,
    input logic              eol_o,
    input logic [WORD_W-1:0] saved_buf_ptr_o
);
    localparam int LEN_W = $clog2(MAX_CHUNK + 1);
    logic [LEN_W-1:0] seen_q;

    // Count bytes accepted since the last chunk end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= '0;
        else if (out_valid_o && out_ready_i)
            seen_q <= out_last_o ? '0 : seen_q + LEN_W'(1);
    end

    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (seen_q < LEN_W'(MAX_CHUNK))); // R4
    AST_CHUNK_LAST_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && seen_q == LEN_W'(MAX_CHUNK - 1)) |-> out_last_o); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o))); // R5
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i) |=> (saved_buf_ptr_o == $past(saved_buf_ptr_o) + WORD_W'(1))); // R6
    AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o || eol_o) |-> !out_valid_o); // R11
    AST_EOL_NOT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |-> !running_o); // R11
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o) && $stable(mem_wdata_o))); // R13
endmodule

bind dcr_chain_reader dcr_chain_reader_chk #(.WORD_W(WORD_W), .MAX_CHUNK(MAX_CHUNK)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .out_valid_o     (out_valid_o),
    .out_ready_i     (out_ready_i),
    .out_data_o      (out_data_o),
    .out_last_o      (out_last_o),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_wdata_o     (mem_wdata_o),
    .mem_ack_i       (mem_ack_i),
    .running_o       (running_o),
    .eol_o           (eol_o),
    .saved_buf_ptr_o (saved_buf_ptr_o)
);

// File: tb/dcr_chain_reader_test.sv
module dcr_chain_reader_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1024;
    localparam int CAP_DEPTH  = 2100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] desc_addr_i = '0, ctx_addr_i = '0;
    logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
    logic        out_valid_o, out_ready_i = 1'b1, out_last_o, data_irq_o;
    logic [7:0]  out_data_o;
    logic        running_o, eol_o;
    logic [31:0] saved_desc_ptr_o, saved_buf_ptr_o;

    logic [31:0] mem [MEM_WORDS];
    logic [7:0]  cap_data [CAP_DEPTH];
    logic        cap_last [CAP_DEPTH];
    int          n_bytes, n_irq, n_wr, cyc;
    int          checks = 0, errors = 0;
    bit          stall_mode = 1'b0, finished = 1'b0;

    dcr_chain_reader uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13 + 5) & 255);
    endfunction

    // Memory model: one-cycle acknowledge, read data with acknowledge.
    initial begin
        forever begin
            @(posedge clk);
            if (!rst_n) mem_ack_i <= 1'b0;
            else if (mem_req_o && !mem_ack_i) begin
                mem_ack_i <= 1'b1;
                if (mem_we_o) begin
                    mem[(mem_addr_o >> 2) & (MEM_WORDS-1)] = mem_wdata_o;
                    n_wr++;
                end else
                    mem_rdata_i <= mem[(mem_addr_o >> 2) & (MEM_WORDS-1)];
            end else mem_ack_i <= 1'b0;
        end
    end

    // Client ready pattern, changed just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            out_ready_i <= stall_mode ? (cyc % 3 != 0) : 1'b1;
        end
    end

    // Monitor, sampled on the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (out_valid_o && out_ready_i && n_bytes < CAP_DEPTH) begin
                    cap_data[n_bytes] = out_data_o;
                    cap_last[n_bytes] = out_last_o;
                    n_bytes++;
                end
                if (data_irq_o) n_irq++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic put_desc(input int at, input int nxt, input int st, input int flg, input int en);
        mem[at/4]     = nxt;
        mem[at/4 + 1] = st;
        mem[at/4 + 2] = flg;
        mem[at/4 + 3] = en;
    endtask

    task automatic launch(input int d, input int c);
        n_bytes = 0; n_irq = 0; n_wr = 0;
        @(negedge clk);
        desc_addr_i = d; ctx_addr_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_eol();
        for (int i = 0; i < 20000 && !eol_o; i++) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic check_bytes(input int first, input int base, input int cnt, input string req);
        for (int i = 0; i < cnt; i++)
            if (cap_data[first + i] !== pat(base + i)) begin
                check(1'b0, req, cap_data[first + i], pat(base + i));
                return;
            end
        check(1'b1, req, 0, 0);
    endtask

    task automatic t_reset();
        check(!running_o && !eol_o && !out_valid_o && !mem_req_o && !data_irq_o, "R1 flags", 0, 0);
        check(saved_desc_ptr_o == 0 && saved_buf_ptr_o == 0, "R1 pointers", saved_buf_ptr_o, 0);
    endtask

    task automatic t_single_unaligned();
        put_desc('h030, 0, 'h201, 'h11, 'h206);
        mem['h0D4/4] = 32'h0000_0000;
        launch('h030, 'h0D0);
        check(running_o && !eol_o, "R2 running after start", running_o, 1);
        wait_eol();
        check(n_bytes == 5, "R3 byte count", n_bytes, 5);
        check_bytes(0, 'h201, 5, "R3 unaligned bytes");
        check(cap_last[4] && !cap_last[0] && !cap_last[3], "R4 last on final byte", cap_last[4], 1);
        check(n_irq == 1, "R8 irq pulse", n_irq, 1);
        check(saved_buf_ptr_o == 'h206, "R6 pointer at end", saved_buf_ptr_o, 'h206);
        check(mem['h0D4/4] == 32'h0000_8000, "R11 context disable", mem['h0D4/4], 32'h8000);
        check(n_wr == 5 && mem['h038/4] == 'h11 && mem['h03C/4] == 'h206, "R9 write-back", n_wr, 5);
        check(eol_o && !running_o, "R11 stopped", eol_o, 1);
    endtask

    task automatic t_chain();
        put_desc('h000, 'h010, 'h300, 0, 'h303);
        put_desc('h010, 'h020, 'h310, 'h10, 'h310);
        put_desc('h020, 0, 'h322, 32'hABCD_0001, 'h326);
        mem['h0C4/4] = 32'h1234_0081;
        launch('h000, 'h0C0);
        wait_eol();
        check(n_bytes == 7, "R7 zero-length adds no bytes", n_bytes, 7);
        check_bytes(0, 'h300, 3, "R10 first buffer");
        check_bytes(3, 'h322, 4, "R10 third buffer");
        check(cap_last[2] && cap_last[6] && !cap_last[3], "R4 chunk per descriptor", cap_last[2], 1);
        check(n_irq == 1, "R8 irq only on flagged", n_irq, 1);
        check(saved_desc_ptr_o == 'h020, "R10 saved descriptor", saved_desc_ptr_o, 'h020);
        check(mem['h0C4/4] == 32'h1234_8081, "R11 context bits kept", mem['h0C4/4], 32'h1234_8081);
        check(n_wr == 13, "R9 write count", n_wr, 13);
        repeat (20) @(negedge clk);
        check(n_bytes == 7, "R11 no bytes after end", n_bytes, 7);
    endtask

    task automatic t_cap_stall();
        put_desc('h040, 0, 'h400, 'h1, 'hC02);
        mem['h0E4/4] = 32'h0;
        stall_mode = 1'b1;
        launch('h040, 'h0E0);
        repeat (200) @(negedge clk);
        desc_addr_i = 'h000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(saved_desc_ptr_o == 'h040 && running_o, "R12 start ignored", saved_desc_ptr_o, 'h040);
        wait_eol();
        stall_mode = 1'b0;
        check(n_bytes == 2050, "R5 all bytes under stall", n_bytes, 2050);
        check_bytes(0, 'h400, 2050, "R3 long buffer");
        check(cap_last[2047] && cap_last[2049] && !cap_last[2046] && !cap_last[2048], "R4 cap at 2048", cap_last[2047], 1);
        check(n_irq == 0, "R8 no irq without flag", n_irq, 0);
        check(saved_buf_ptr_o == 'hC02, "R6 pointer at end", saved_buf_ptr_o, 'hC02);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int w = 0; w < MEM_WORDS; w++)
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_unaligned();
        t_chain();
        t_cap_stall();
        finish_run();
    end
endmodule